// File: doc/BRIEF.md
# Interrupt presentation controller

This block sits next to one processor and decides which single interrupt is presented to it. It keeps a 32-bit presentation word made of the processor's current priority and the number of the source now pending, and beside it the priority of that pending source and the priority at which an inter-processor interrupt (IPI) is requested. A source controller offers interrupts as (source, priority) pairs. The block either takes an offer and raises its interrupt line, or hands the offer back. Any time a held interrupt is displaced or cancelled, that source goes back to the source controller as well.

The processor side issues four commands, one per cycle, through a valid strobe and a 2-bit opcode. It can set its current priority, set the IPI priority, accept the pending interrupt, or signal end of interrupt. The block answers the source controller with single-cycle reject, end-of-interrupt and resend strobes. Priorities follow the rule that a smaller number is more urgent, and the all-ones value masks everything.

Top module: `irq_present_unit`

## Requirements
- R1: After reset the line `irq_out` is low, the word on `accept_word` is zero, and no strobe is active. Internally the pending and IPI priorities hold 0xFF.
- R2: `accept_word` shows the current priority in bits [31:24] and the pending source number in bits [23:0]. A source field of zero means nothing is pending. A numerically smaller priority wins, and 0xFF is the least favoured value.
- R3: An offer seen while `cmd_valid` is low is refused when either of two conditions holds: its priority is not below the current priority, or a source is already pending with a priority at or below the offer's. On a refusal, `reject_valid` pulses on the next cycle with `reject_src` equal to the offered source.
- R4: An offer that is not refused replaces the pending source and its priority, and `irq_out` is high on the next cycle. If a source was already pending, it is rejected through `reject_valid`/`reject_src` on that same next cycle.
- R5: Opcode 1 writes `cmd_data[7:0]` as the IPI priority. If that value is below the current priority, the IPI check runs. The check leaves the state alone when a pending source has a priority at or below the IPI priority. Otherwise it rejects any pending source, loads source number 2 with the IPI priority, and raises `irq_out`.
- R6: Opcode 0 writes `cmd_data[7:0]` as the current priority. A value below the old priority that is at or below the pending priority cancels the pending source: the source field clears, the pending priority becomes 0xFF, `irq_out` drops, and that source is rejected. A value below the old priority but above the pending priority leaves the pending source in place.
- R7: Opcode 0 with a value at or above the old priority, while nothing is pending, pulses `resend_req`. In that same step the IPI source is presented if the IPI priority is below the new current priority.
- R8: Opcode 2 is accept. The presentation word is on `accept_word` in the cycle the command is given. On the next cycle `irq_out` is low, the current priority equals the former pending priority, the source field is zero, and the pending priority is 0xFF.
- R9: Opcode 3 is end of interrupt. `cmd_data[31:24]` becomes the current priority, and `eoi_valid` pulses on the next cycle with `eoi_src` equal to `cmd_data[23:0]`. If nothing is pending, `resend_req` pulses as well, and the IPI check runs against the new current priority.
- R10: Reject, end-of-interrupt and resend strobes are single-cycle pulses registered one cycle after the command or offer that causes them. `irq_out` is high exactly when the source field is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_src | input | 24 | Offered source number (non-zero) |
| offer_prio | input | 8 | Offered priority |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_op | input | 2 | 0 set priority, 1 set IPI priority, 2 accept, 3 end of interrupt |
| cmd_data | input | 32 | Command operand |
| accept_word | output | 32 | Current presentation word (priority and source) |
| irq_out | output | 1 | Interrupt line to the processor |
| reject_valid | output | 1 | Reject strobe to the source controller |
| reject_src | output | 24 | Source being handed back |
| eoi_valid | output | 1 | End-of-interrupt strobe to the source controller |
| eoi_src | output | 24 | Source being completed |
| resend_req | output | 1 | Request for the sources to offer again |

## Verification
The assertions rely on three conditions. Offers carry a non-zero source number. An offer is never presented in a cycle where a command is valid, since the command wins and the offer would be lost. The source controller does not drop a reject, because each rule produces at most one reject per cycle. The stimulus meets all three: directed sequences walk each priority rule, and the random phase draws an offer only in cycles with no command, using source numbers from 3 upward so the IPI number 2 is never offered from outside.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

   typedef enum logic [1:0] {
      OP_SET_PRIO = 2'd0,
      OP_SET_IPI  = 2'd1,
      OP_ACCEPT   = 2'd2,
      OP_EOI      = 2'd3
   } ipc_op_e;

   localparam int DEF_SRC_W  = 24;
   localparam int DEF_PRIO_W = 8;
   localparam int DEF_IPI_SRC = 2;

endpackage

// File: rtl/ipc_offer_eval.sv
// Decides whether an offered interrupt beats the processor priority and
// whatever is already held.
module ipc_offer_eval #(
   parameter int PRIO_W = 8
) (
   input  logic [PRIO_W-1:0] offer_prio,
   input  logic [PRIO_W-1:0] cur_prio,
   input  logic [PRIO_W-1:0] held_prio,
   input  logic              held_busy,
   output logic              take,
   output logic              drop_held
);

   logic beats_cpu;
   logic beats_held;

   always_comb begin
      beats_cpu  = offer_prio < cur_prio;
      beats_held = !held_busy || (offer_prio < held_prio);
      take       = beats_cpu && beats_held;
      drop_held  = take && held_busy;
   end

endmodule

// File: rtl/ipc_ipi_eval.sv
// Evaluates the inter-processor interrupt check against a given current
// priority and IPI priority.
module ipc_ipi_eval #(
   parameter int PRIO_W = 8
) (
   input  logic [PRIO_W-1:0] ipi_prio,
   input  logic [PRIO_W-1:0] cur_prio,
   input  logic [PRIO_W-1:0] held_prio,
   input  logic              held_busy,
   output logic              fire,
   output logic              drop_held
);

   logic enabled;
   logic held_wins;

   always_comb begin
      enabled   = ipi_prio < cur_prio;
      held_wins = held_busy && (held_prio <= ipi_prio);
      fire      = enabled && !held_wins;
      drop_held = fire && held_busy;
   end

endmodule

// File: rtl/ipc_strobe_stage.sv
// Output stage for the strobes toward the source controller; PIPE picks
// a registered or a pass-through variant.
module ipc_strobe_stage #(
   parameter int SRC_W = 24,
   parameter bit PIPE  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rej_v_in,
   input  logic [SRC_W-1:0] rej_s_in,
   input  logic             eoi_v_in,
   input  logic [SRC_W-1:0] eoi_s_in,
   input  logic             rs_v_in,
   output logic             rej_v,
   output logic [SRC_W-1:0] rej_s,
   output logic             eoi_v,
   output logic [SRC_W-1:0] eoi_s,
   output logic             rs_v
);

   generate
      if (PIPE) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rej_v <= 1'b0;
               rej_s <= '0;
               eoi_v <= 1'b0;
               eoi_s <= '0;
               rs_v  <= 1'b0;
            end else begin
               rej_v <= rej_v_in;
               rej_s <= rej_v_in ? rej_s_in : '0;
               eoi_v <= eoi_v_in;
               eoi_s <= eoi_v_in ? eoi_s_in : '0;
               rs_v  <= rs_v_in;
            end
         end
      end else begin : g_comb
         assign rej_v = rej_v_in;
         assign rej_s = rej_v_in ? rej_s_in : '0;
         assign eoi_v = eoi_v_in;
         assign eoi_s = eoi_v_in ? eoi_s_in : '0;
         assign rs_v  = rs_v_in;
      end
   endgenerate

endmodule

// File: rtl/irq_present_unit.sv
module irq_present_unit #(
   parameter int SRC_W       = ipc_pkg::DEF_SRC_W,
   parameter int PRIO_W      = ipc_pkg::DEF_PRIO_W,
   parameter int IPI_SRC     = ipc_pkg::DEF_IPI_SRC,
   parameter bit STROBE_PIPE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      offer_valid,
   input  logic [SRC_W-1:0]          offer_src,
   input  logic [PRIO_W-1:0]         offer_prio,
   input  logic                      cmd_valid,
   input  logic [1:0]                cmd_op,
   input  logic [SRC_W+PRIO_W-1:0]   cmd_data,
   output logic [SRC_W+PRIO_W-1:0]   accept_word,
   output logic                      irq_out,
   output logic                      reject_valid,
   output logic [SRC_W-1:0]          reject_src,
   output logic                      eoi_valid,
   output logic [SRC_W-1:0]          eoi_src,
   output logic                      resend_req
);
   import ipc_pkg::*;

   localparam int WORD_W = SRC_W + PRIO_W;
   localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;
   localparam logic [SRC_W-1:0]  IPI_CODE    = SRC_W'(IPI_SRC);

   generate
      if (SRC_W < 2 || PRIO_W < 2) begin : g_bad_width
         $error("irq_present_unit: SRC_W and PRIO_W must be at least 2");
      end
      if (IPI_SRC <= 0 || IPI_SRC >= (1 << SRC_W)) begin : g_bad_ipi
         $error("irq_present_unit: IPI_SRC must be non-zero and fit SRC_W");
      end
   endgenerate

   // architectural state
   logic [PRIO_W-1:0] r_cppr, n_cppr;
   logic [SRC_W-1:0]  r_xsrc, n_xsrc;
   logic [PRIO_W-1:0] r_pend, n_pend;
   logic [PRIO_W-1:0] r_ipip, n_ipip;
   logic              r_irq,  n_irq;

   // unregistered strobe requests
   logic             q_rej_v, q_eoi_v, q_rs_v;
   logic [SRC_W-1:0] q_rej_s, q_eoi_s;

   ipc_op_e           op;
   logic              busy;
   logic [PRIO_W-1:0] arg_prio;
   logic [PRIO_W-1:0] arg_top;
   logic [PRIO_W-1:0] ipi_prio_eff;
   logic [PRIO_W-1:0] ipi_cppr_eff;
   logic              ipi_fire, ipi_drop;
   logic              off_take, off_drop;

   assign op       = ipc_op_e'(cmd_op);
   assign busy     = (r_xsrc != '0);
   assign arg_prio = cmd_data[PRIO_W-1:0];
   assign arg_top  = cmd_data[WORD_W-1 -: PRIO_W];

   // The IPI check sees the priorities as they stand after the command.
   always_comb begin
      ipi_prio_eff = r_ipip;
      ipi_cppr_eff = r_cppr;
      if (cmd_valid) begin
         case (op)
            OP_SET_IPI:  ipi_prio_eff = arg_prio;
            OP_SET_PRIO: ipi_cppr_eff = arg_prio;
            OP_EOI:      ipi_cppr_eff = arg_top;
            default:     ipi_cppr_eff = r_cppr;
         endcase
      end
   end

   ipc_ipi_eval #(.PRIO_W(PRIO_W)) ipi_i (
      .ipi_prio  (ipi_prio_eff),
      .cur_prio  (ipi_cppr_eff),
      .held_prio (r_pend),
      .held_busy (busy),
      .fire      (ipi_fire),
      .drop_held (ipi_drop)
   );

   ipc_offer_eval #(.PRIO_W(PRIO_W)) offer_i (
      .offer_prio (offer_prio),
      .cur_prio   (r_cppr),
      .held_prio  (r_pend),
      .held_busy  (busy),
      .take       (off_take),
      .drop_held  (off_drop)
   );

   always_comb begin
      n_cppr  = r_cppr;
      n_xsrc  = r_xsrc;
      n_pend  = r_pend;
      n_ipip  = r_ipip;
      n_irq   = r_irq;
      q_rej_v = 1'b0;
      q_rej_s = r_xsrc;
      q_eoi_v = 1'b0;
      q_eoi_s = cmd_data[SRC_W-1:0];
      q_rs_v  = 1'b0;

      if (cmd_valid) begin
         case (op)
            OP_SET_PRIO: begin
               n_cppr = arg_prio;
               if (arg_prio < r_cppr) begin
                  if (busy && (arg_prio <= r_pend)) begin
                     n_xsrc  = '0;
                     n_pend  = PRIO_MASKED;
                     n_irq   = 1'b0;
                     q_rej_v = 1'b1;
                  end
               end else if (!busy) begin
                  q_rs_v = 1'b1;
                  if (ipi_fire) begin
                     n_xsrc = IPI_CODE;
                     n_pend = r_ipip;
                     n_irq  = 1'b1;
                  end
               end
            end
            OP_SET_IPI: begin
               n_ipip = arg_prio;
               if (ipi_fire) begin
                  q_rej_v = ipi_drop;
                  n_xsrc  = IPI_CODE;
                  n_pend  = arg_prio;
                  n_irq   = 1'b1;
               end
            end
            OP_ACCEPT: begin
               n_cppr = r_pend;
               n_xsrc = '0;
               n_pend = PRIO_MASKED;
               n_irq  = 1'b0;
            end
            OP_EOI: begin
               n_cppr  = arg_top;
               q_eoi_v = 1'b1;
               if (!busy) begin
                  q_rs_v = 1'b1;
                  if (ipi_fire) begin
                     n_xsrc = IPI_CODE;
                     n_pend = r_ipip;
                     n_irq  = 1'b1;
                  end
               end
            end
            default: n_cppr = r_cppr;
         endcase
      end else if (offer_valid) begin
         if (off_take) begin
            q_rej_v = off_drop;
            n_xsrc  = offer_src;
            n_pend  = offer_prio;
            n_irq   = 1'b1;
         end else begin
            q_rej_v = 1'b1;
            q_rej_s = offer_src;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_cppr <= '0;
         r_xsrc <= '0;
         r_pend <= PRIO_MASKED;
         r_ipip <= PRIO_MASKED;
         r_irq  <= 1'b0;
      end else begin
         r_cppr <= n_cppr;
         r_xsrc <= n_xsrc;
         r_pend <= n_pend;
         r_ipip <= n_ipip;
         r_irq  <= n_irq;
      end
   end

   ipc_strobe_stage #(.SRC_W(SRC_W), .PIPE(STROBE_PIPE)) strobe_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rej_v_in (q_rej_v),
      .rej_s_in (q_rej_s),
      .eoi_v_in (q_eoi_v),
      .eoi_s_in (q_eoi_s),
      .rs_v_in  (q_rs_v),
      .rej_v    (reject_valid),
      .rej_s    (reject_src),
      .eoi_v    (eoi_valid),
      .eoi_s    (eoi_src),
      .rs_v     (resend_req)
   );

   assign accept_word = {r_cppr, r_xsrc};
   assign irq_out     = r_irq;

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
   parameter int SRC_W       = 24,
   parameter int PRIO_W      = 8,
   parameter int IPI_SRC     = 2,
   parameter bit STROBE_PIPE = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    offer_valid,
   input logic [SRC_W-1:0]        offer_src,
   input logic [PRIO_W-1:0]       offer_prio,
   input logic                    cmd_valid,
   input logic [1:0]              cmd_op,
   input logic [SRC_W+PRIO_W-1:0] cmd_data,
   input logic                    irq_out,
   input logic                    reject_valid,
   input logic [SRC_W-1:0]        reject_src,
   input logic                    eoi_valid,
   input logic [SRC_W-1:0]        eoi_src,
   input logic [PRIO_W-1:0]       cppr,
   input logic [SRC_W-1:0]        xsrc,
   input logic [PRIO_W-1:0]       pend
);

   localparam logic [PRIO_W-1:0] P_MASK = '1;
   localparam logic [SRC_W-1:0]  IPI_C  = SRC_W'(IPI_SRC);

   logic offer_only;
   assign offer_only = offer_valid && !cmd_valid;

   a_r10_line_follows_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (xsrc != '0));

   a_r2_idle_prio_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (xsrc == '0) |-> (pend == P_MASK));

   a_r8_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd2) |=> (!irq_out && xsrc == '0 && cppr == $past(pend)));

   a_r4_offer_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (offer_only && offer_prio < cppr && (xsrc == '0 || pend > offer_prio))
      |=> (irq_out && xsrc == $past(offer_src) && pend == $past(offer_prio)));

   a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd0 && cmd_data[PRIO_W-1:0] < cppr && xsrc != '0
       && cmd_data[PRIO_W-1:0] <= pend) |=> (!irq_out && xsrc == '0));

   a_r5_ipi_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd1 && cmd_data[PRIO_W-1:0] < cppr && xsrc == '0)
      |=> (xsrc == IPI_C && irq_out));

   generate
      if (STROBE_PIPE) begin : g_strobe_checks
         a_r3_refused_offer: assert property (@(posedge clk) disable iff (!rst_n)
            (offer_only && offer_prio >= cppr)
            |=> (reject_valid && reject_src == $past(offer_src)));

         a_r9_eoi_forward: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && cmd_op == 2'd3)
            |=> (eoi_valid && eoi_src == $past(cmd_data[SRC_W-1:0])));
      end
   endgenerate

endmodule

bind irq_present_unit ipc_checker #(
   .SRC_W(SRC_W), .PRIO_W(PRIO_W), .IPI_SRC(IPI_SRC), .STROBE_PIPE(STROBE_PIPE)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .offer_valid  (offer_valid),
   .offer_src    (offer_src),
   .offer_prio   (offer_prio),
   .cmd_valid    (cmd_valid),
   .cmd_op       (cmd_op),
   .cmd_data     (cmd_data),
   .irq_out      (irq_out),
   .reject_valid (reject_valid),
   .reject_src   (reject_src),
   .eoi_valid    (eoi_valid),
   .eoi_src      (eoi_src),
   .cppr         (r_cppr),
   .xsrc         (r_xsrc),
   .pend         (r_pend)
);

// File: tb/irq_present_unit_tb_top.sv
module irq_present_unit_tb_top;

   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        offer_valid = 1'b0;
   logic [23:0] offer_src = '0;
   logic [7:0]  offer_prio = '0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [31:0] cmd_data = '0;
   logic [31:0] accept_word;
   logic        irq_out;
   logic        reject_valid;
   logic [23:0] reject_src;
   logic        eoi_valid;
   logic [23:0] eoi_src;
   logic        resend_req;

   irq_present_unit dut_i (
      .clk(clk), .rst_n(rst_n),
      .offer_valid(offer_valid), .offer_src(offer_src), .offer_prio(offer_prio),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
      .accept_word(accept_word), .irq_out(irq_out),
      .reject_valid(reject_valid), .reject_src(reject_src),
      .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
   );

   always #(CLK_NS/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference model state
   int unsigned m_cur, m_src, m_pend, m_ipi, m_line;
   int unsigned x_rej, x_rej_src, x_eoi, x_eoi_src, x_rs;

   task automatic check(input string tag, input string what,
                        input int unsigned act, input int unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic m_hand_back(input int unsigned s);
      x_rej = 1; x_rej_src = s;
   endtask

   task automatic m_ipi_check();
      if (m_src != 0 && m_pend <= m_ipi) return;
      if (m_src != 0) m_hand_back(m_src);
      m_src = 2; m_pend = m_ipi; m_line = 1;
   endtask

   task automatic m_resend();
      x_rs = 1;
      if (m_ipi < m_cur) m_ipi_check();
   endtask

   task automatic m_apply(input bit cv, input int unsigned op, input int unsigned d,
                          input bit ov, input int unsigned os, input int unsigned opr);
      int unsigned prev;
      x_rej = 0; x_rej_src = 0; x_eoi = 0; x_eoi_src = 0; x_rs = 0;
      if (cv) begin
         case (op)
            0: begin
               prev = m_cur; m_cur = d & 8'hFF;
               if (m_cur < prev) begin
                  if (m_src != 0 && m_cur <= m_pend) begin
                     m_hand_back(m_src); m_src = 0; m_pend = 8'hFF; m_line = 0;
                  end
               end else if (m_src == 0) m_resend();
            end
            1: begin
               m_ipi = d & 8'hFF;
               if (m_ipi < m_cur) m_ipi_check();
            end
            2: begin
               m_line = 0; m_cur = m_pend; m_src = 0; m_pend = 8'hFF;
            end
            default: begin
               m_cur = d >> 24; x_eoi = 1; x_eoi_src = d & 24'hFFFFFF;
               if (m_src == 0) m_resend();
            end
         endcase
      end else if (ov) begin
         if (opr >= m_cur || (m_src != 0 && m_pend <= opr)) m_hand_back(os);
         else begin
            if (m_src != 0) m_hand_back(m_src);
            m_src = os; m_pend = opr; m_line = 1;
         end
      end
   endtask

   // one clock: drive at the falling edge, compare one cycle later
   task automatic step(input string tag, input bit cv, input logic [1:0] op,
                       input logic [31:0] d, input bit ov, input logic [23:0] os,
                       input logic [7:0] opr);
      cmd_valid = cv; cmd_op = op; cmd_data = d;
      offer_valid = ov; offer_src = os; offer_prio = opr;
      #1;
      if (cv && op == 2'd2)
         check(tag, "accept word", accept_word, (m_cur << 24) | m_src);
      m_apply(cv, op, d, ov, os, opr);
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0; offer_valid = 1'b0;
      check(tag, "irq_out", irq_out, m_line);
      check(tag, "reject_valid", reject_valid, x_rej);
      if (x_rej != 0) check(tag, "reject_src", reject_src, x_rej_src);
      check(tag, "eoi_valid", eoi_valid, x_eoi);
      if (x_eoi != 0) check(tag, "eoi_src", eoi_src, x_eoi_src);
      check(tag, "resend_req", resend_req, x_rs);
   endtask

   task automatic cmd(input string tag, input logic [1:0] op, input logic [31:0] d);
      step(tag, 1'b1, op, d, 1'b0, 24'h0, 8'h0);
   endtask

   task automatic offer(input string tag, input logic [23:0] s, input logic [7:0] p);
      step(tag, 1'b0, 2'd0, 32'h0, 1'b1, s, p);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      m_cur = 0; m_src = 0; m_pend = 8'hFF; m_ipi = 8'hFF; m_line = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check("R1", "irq_out", irq_out, 0);
      check("R1", "accept_word", accept_word, 0);
      check("R1", "strobes", {reject_valid, eoi_valid, resend_req}, 0);

      offer("R3", 24'h5, 8'h3);            // current priority 0 refuses everything
      cmd("R7", 2'd0, 32'hFF);             // raise with nothing pending: resend
      offer("R4", 24'h10, 8'h5);
      offer("R3", 24'h11, 8'h5);           // equal to held priority: refused
      offer("R4", 24'h12, 8'h3);           // displaces 0x10
      cmd("R8", 2'd2, 32'h0);              // word {FF,12}; current becomes 3
      check("R2", "word layout", accept_word, 32'h0300_0000);
      offer("R3", 24'h13, 8'h3);           // not below current
      cmd("R9", 2'd3, 32'hFF00_0012);      // restore FF, resend
      cmd("R5", 2'd1, 32'h40);             // IPI loads
      check("R5", "ipi source", accept_word, 32'hFF00_0002);
      cmd("R5", 2'd1, 32'h20);             // displaces the IPI itself
      cmd("R5", 2'd1, 32'h30);             // held 0x20 wins, nothing changes
      cmd("R6", 2'd0, 32'h10);             // cancel
      cmd("R7", 2'd0, 32'h40);             // resend + IPI at 0x30
      cmd("R6", 2'd0, 32'h38);             // lower, but held 0x30 stays
      check("R6", "held kept", accept_word, 32'h3800_0002);
      cmd("R8", 2'd2, 32'h0);
      cmd("R9", 2'd3, 32'h8000_0002);      // resend, IPI again
      cmd("R10", 2'd2, 32'h0);

      // random phase against the reference model
      for (int i = 0; i < 3000; i++) begin
         int unsigned r;
         r = $urandom_range(0, 9);
         if (r < 5) begin
            logic [1:0] op;
            logic [31:0] d;
            op = 2'($urandom_range(0, 3));
            d  = {8'($urandom_range(0, 255)), 24'($urandom_range(3, 300))};
            cmd("R10", op, d);
         end else if (r < 9) begin
            offer("R4", 24'($urandom_range(3, 300)), 8'($urandom_range(0, 255)));
         end else begin
            step("R10", 1'b0, 2'd0, 32'h0, 1'b0, 24'h0, 8'h0);
         end
      end

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule